// File: doc/BRIEF.md
# Split-Capable Bus Arbiter

This block decides which client may drive a shared parallel bus next. Clients are initiators and targets in one index space: initiators sit at the low indices and targets above them. Each client has an active-low request line and receives an active-low grant line. Targets can request the bus so that they can return data for a split completion.

The arbiter watches the active-low frame and ready strobes to see when the bus is idle. It drives at most one grant at a time. A grant stays with its owner until the owner lets go.

A small mode register sets how grants are given. It holds a two-bit operating mode and a split-enable bit. Mode code 0 is disabled, 1 is the plain mode, 2 is the mode that needs an idle clock between transactions, and 3 is reserved. A write strobe loads the register.

Top module: `split_bus_arbiter`

## Requirements
- R1: After reset every `gnt_n` line is high, the mode is 0 (disabled) and split is off.
- R2: No more than one `gnt_n` line is low in any cycle.
- R3: A new grant is issued only while the registered mode code is 1 or 2. With code 0 or 3 no new grant appears.
- R4: When several eligible clients of the same class request, the grant goes to the lowest index.
- R5: A grant stays unchanged while its owner holds `req_n` low, or while `frame_n` or `irdy_n` is low. It is withdrawn at the first edge where the owner's `req_n` is high and both `frame_n` and `irdy_n` are high.
- R6: No new grant is issued while a grant is active, or at an edge where `frame_n` or `irdy_n` is low.
- R7: If a grant is released while the mode code is 2, the following edge issues no grant, so the next grant comes two edges after the release. With mode code 1 the next grant may come on the edge right after the release.
- R8: Target indices (N_INIT up to N_INIT+N_TGT-1) are ignored while split is 0. While split is 1, any requesting target wins over all initiators, and the lowest requesting target index is chosen.
- R9: A mode register write (`cfg_wr` high at an edge) loads `cfg_mode` and `cfg_split`. The new values govern grant decisions from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode register load strobe |
| cfg_mode | input | 2 | Mode code: 0 off, 1 plain, 2 idle-gap, 3 reserved |
| cfg_split | input | 1 | Split completion enable |
| req_n | input | N_INIT+N_TGT | Active-low requests, initiators first |
| frame_n | input | 1 | Active-low bus frame strobe |
| irdy_n | input | 1 | Active-low initiator ready strobe |
| gnt_n | output | N_INIT+N_TGT | Active-low grants |

## Verification
The directed part of the bench drives several patterns. A lone request while the mode is disabled shows the mode gate works. Two initiators competing show the index priority. A release held back by a busy frame or ready strobe separates request release from bus release. Targets and initiators requesting together distinguish split-on from split-off. Releases under mode 1 and under mode 2 show whether the idle clock is inserted. A long stretch of random requests, strobes and mode writes is then compared against a behavioural model on every clock. This catches ordering slips between release, gap and new grant.

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter #(
  parameter int N_INIT = 4,
  parameter int N_TGT  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [1:0]                cfg_mode,
  input  logic                      cfg_split,
  input  logic [N_INIT+N_TGT-1:0]   req_n,
  input  logic                      frame_n,
  input  logic                      irdy_n,
  output logic [N_INIT+N_TGT-1:0]   gnt_n
);
  localparam int NREQ = N_INIT + N_TGT;
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [NREQ-1:0] TGT_MASK = {{N_TGT{1'b1}}, {N_INIT{1'b0}}};
  localparam logic [1:0] MODE_PLAIN = 2'd1;
  localparam logic [1:0] MODE_GAP   = 2'd2;

  logic [1:0]      mode_q;
  logic            split_q;
  logic            own_v;
  logic [IW-1:0]   own_q;
  logic            gap_q;
  logic [NREQ-1:0] gnt_q;

  logic [NREQ-1:0] want, tgt_want, ini_want, pool;
  logic [IW-1:0]   win_idx;
  logic            bus_idle, mode_ok, owner_done, issue;

  assign bus_idle   = frame_n & irdy_n;
  assign want       = ~req_n;
  assign tgt_want   = split_q ? (want & TGT_MASK) : '0;
  assign ini_want   = want & ~TGT_MASK;
  assign pool       = (|tgt_want) ? tgt_want : ini_want;
  assign mode_ok    = (mode_q == MODE_PLAIN) || (mode_q == MODE_GAP);
  assign owner_done = own_v & req_n[own_q] & bus_idle;
  assign issue      = ~own_v & ~gap_q & mode_ok & bus_idle & (|pool);
  assign gnt_n      = ~gnt_q;

  always_comb begin
    win_idx = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (pool[i]) win_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      split_q <= 1'b0;
      own_v   <= 1'b0;
      own_q   <= '0;
      gap_q   <= 1'b0;
      gnt_q   <= '0;
    end else begin
      if (cfg_wr) begin
        mode_q  <= cfg_mode;
        split_q <= cfg_split;
      end
      gap_q <= owner_done && (mode_q == MODE_GAP);
      if (owner_done) begin
        own_v <= 1'b0;
        gnt_q <= '0;
      end else if (issue) begin
        own_v <= 1'b1;
        own_q <= win_idx;
        gnt_q <= NREQ'(1) << win_idx;
      end
    end
  end
endmodule

// File: rtl/split_bus_arbiter_chk.sv
module split_bus_arbiter_chk #(
  parameter int N_INIT = 4,
  parameter int N_TGT  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_INIT+N_TGT-1:0] req_n,
  input logic                    frame_n,
  input logic                    irdy_n,
  input logic [N_INIT+N_TGT-1:0] gnt_n,
  input logic [1:0]              mode_q,
  input logic                    split_q
);
  localparam int NREQ = N_INIT + N_TGT;

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&gnt_n && mode_q != 2'd1 && mode_q != 2'd2) |=> &gnt_n);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~gnt_n & ~req_n)) |=> $stable(gnt_n));

  assert_busy_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&gnt_n && !(frame_n && irdy_n)) |=> &gnt_n);

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&gnt_n && !$past(&gnt_n) && $past(mode_q) == 2'd2) |=> &gnt_n);

  assert_split_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_q && &gnt_n) |=> &gnt_n[NREQ-1:N_INIT]);
endmodule

bind split_bus_arbiter split_bus_arbiter_chk #(.N_INIT(N_INIT), .N_TGT(N_TGT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .gnt_n(gnt_n), .mode_q(mode_q), .split_q(split_q)
);

// File: tb/split_bus_arbiter_test.sv
module split_bus_arbiter_test;
  localparam int NI = 3;
  localparam int NT = 2;
  localparam int N  = NI + NT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_split = 1'b0;
  logic [N-1:0] req_n = '1;
  logic frame_n = 1'b1;
  logic irdy_n = 1'b1;
  logic [N-1:0] gnt_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  int m_own = -1;
  bit m_gap = 1'b0;
  int m_mode = 0;
  bit m_split = 1'b0;

  split_bus_arbiter #(.N_INIT(NI), .N_TGT(NT)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_split(cfg_split), .req_n(req_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = -1; m_gap = 1'b0; m_mode = 0; m_split = 1'b0;
    end else begin
      bit idle, ng;
      idle = frame_n & irdy_n;
      ng = 1'b0;
      if (m_own >= 0) begin
        if (req_n[m_own] && idle) begin
          m_own = -1;
          ng = (m_mode == 2);
        end
      end else if (!m_gap && (m_mode == 1 || m_mode == 2) && idle) begin
        if (m_split)
          for (int k = N - 1; k >= NI; k--) if (!req_n[k]) m_own = k;
        if (m_own < 0)
          for (int k = NI - 1; k >= 0; k--) if (!req_n[k]) m_own = k;
      end
      m_gap = ng;
      if (cfg_wr) begin
        m_mode = int'(cfg_mode);
        m_split = cfg_split;
      end
    end
  end

  function automatic logic [N-1:0] model_gnt();
    return (m_own < 0) ? '1 : ~(N'(1) << m_own);
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gnt_n actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(phase, gnt_n, model_gnt());
      checks++;
      if ($countones(~gnt_n) > 1) begin
        errors++;
        $display("FAIL R2 grant count actual=%0d expected<=1", $countones(~gnt_n));
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(int md, bit sp);
    cfg_wr = 1'b1; cfg_mode = 2'(md); cfg_split = sp;
    cyc();
    cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc();
    check("R1", gnt_n, 5'b11111);

    phase = "R3";
    req_n = 5'b11110;
    cyc(2);
    check("R3", gnt_n, 5'b11111);

    phase = "R9";
    wr_mode(1, 1'b0);
    check("R9", gnt_n, 5'b11111);
    cyc();
    check("R9", gnt_n, 5'b11110);

    phase = "R5";
    frame_n = 1'b0; req_n = 5'b11101;
    cyc();
    check("R5", gnt_n, 5'b11110);
    frame_n = 1'b1; irdy_n = 1'b0;
    cyc();
    check("R5", gnt_n, 5'b11110);
    irdy_n = 1'b1;
    cyc();
    check("R5", gnt_n, 5'b11111);
    phase = "R7";
    cyc();
    check("R7", gnt_n, 5'b11101);

    phase = "R4";
    req_n = 5'b11010;
    cyc();
    check("R4", gnt_n, 5'b11111);
    cyc();
    check("R4", gnt_n, 5'b11110);

    phase = "R8";
    req_n = 5'b00111;
    cyc(2);
    check("R8", gnt_n, 5'b11111);

    phase = "R6";
    req_n = 5'b00011; frame_n = 1'b0;
    cyc();
    check("R6", gnt_n, 5'b11111);
    frame_n = 1'b1;
    cyc();
    check("R6", gnt_n, 5'b11011);
    req_n = 5'b00010;
    cyc();
    check("R6", gnt_n, 5'b11011);

    phase = "R7";
    wr_mode(2, 1'b1);
    req_n = 5'b00110;
    cyc();
    check("R7", gnt_n, 5'b11111);
    cyc();
    check("R7", gnt_n, 5'b11111);
    phase = "R8";
    cyc();
    check("R8", gnt_n, 5'b10111);

    phase = "R3";
    wr_mode(3, 1'b1);
    req_n = 5'b01110;
    cyc();
    check("R3", gnt_n, 5'b11111);
    cyc(2);
    check("R3", gnt_n, 5'b11111);
    wr_mode(1, 1'b1);
    cyc();
    check("R8", gnt_n, 5'b01111);

    phase = "R5";
    for (int t = 0; t < 3000; t++) begin
      req_n = N'($urandom);
      frame_n = ($urandom % 4) != 0;
      irdy_n = ($urandom % 4) != 0;
      cfg_wr = ($urandom % 16) == 0;
      cfg_mode = 2'($urandom);
      cfg_split = 1'($urandom);
      cyc();
    end
    cfg_wr = 1'b0;
    cyc(2);
    finish_run();
  end
endmodule